// File: doc/BRIEF.md
# PFC Supply and Fault Supervisor

This block is the supervisory state machine of a boost power-factor-correction controller. It receives the outputs of the supply, line-sense and feedback comparators as plain logic flags. From them it decides whether the power stage may switch. It drives a gate-enable output, a fault output that discharges the voltage-loop compensation, a standby output that clamps the current-loop compensation node, and a startup-phase indicator. It also reports an over-voltage duty-cut request and a coded cause for the current inhibit.

Two hysteretic enable conditions feed the machine. The supply condition is set by a turn-on flag and cleared by a lockout flag. The line condition is set by a line-high flag and cleared by a line-low flag. An open-loop flag from the feedback comparator is the third condition. Losing the supply puts the block in full lockout (OFF). Losing the line or the loop while the supply is good puts it in STANDBY. When all conditions are good, the block enters STARTUP and stays there until a flag reports that the output has reached its startup target. It then moves to NORMAL.

Every flag is resynchronised by a two-flop synchronizer and captured in a conditioning register before it can reach the state register.

Top module: `pfc_supervisor`

## Requirements
- R1: While reset is held and after its release, with all flags low: state_o = 0 (OFF), gate_en_o = 0, fault_o = 1, standby_o = 0, startup_o = 0, ovp_cut_o = 0, cause_o = 3.
- R2: A flag change made between clock edges reaches cause_o at the third following rising edge and state_o at the fourth, and not earlier.
- R3: Supply hysteresis: the supply condition becomes good on vcc_on_i, becomes bad on vcc_low_i, and keeps its value when both are low. When both are high, vcc_low_i wins.
- R4: A bad supply condition drives the state to OFF (code 0) from any state. In OFF, gate_en_o = 0 and fault_o = 1.
- R5: From OFF with a good supply, the block enters STARTUP (code 1) only when the line and loop conditions are also good. Otherwise it enters STANDBY (code 3).
- R6: Line hysteresis: the line condition becomes bad on line_low_i, becomes good only on line_high_i, and keeps its value when both are low. When both are high, line_low_i wins. A bad line condition with a good supply forces STANDBY.
- R7: fb_open_i with good supply and line forces STANDBY from STARTUP or NORMAL.
- R8: In STANDBY, standby_o = 1, fault_o = 1 and gate_en_o = 0. When supply, line and loop are all good, STANDBY exits to STARTUP.
- R9: In STARTUP, startup_o = 1 and gate_en_o = 1 until out_reached_i is seen. The state then becomes NORMAL (code 2), where startup_o = 0 and gate_en_o = 1.
- R10: ovp_cut_o = 1 only while the gate is enabled and the over-voltage flag is set. Over-voltage never changes the state.
- R11: cause_o gives the highest-priority inhibit: 3 = supply lockout, 2 = line brown-out, 1 = open loop, 0 = none. Lockout ranks above brown-out, and brown-out ranks above open loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_low_i | input | 1 | Supply below lockout level |
| line_high_i | input | 1 | Line-sense above the upper brown-out threshold |
| line_low_i | input | 1 | Line-sense below the lower brown-out threshold |
| fb_open_i | input | 1 | Feedback below the open-loop threshold |
| fb_ovp_i | input | 1 | Feedback above the over-voltage threshold |
| out_reached_i | input | 1 | Output has reached the startup-complete level |
| state_o | output | 2 | State code: 0 OFF, 1 STARTUP, 2 NORMAL, 3 STANDBY |
| cause_o | output | 2 | Inhibit cause code (see R11) |
| gate_en_o | output | 1 | Gate drive enable |
| fault_o | output | 1 | Voltage-loop compensation discharge |
| standby_o | output | 1 | Current-loop compensation clamp |
| startup_o | output | 1 | Startup phase indicator |
| ovp_cut_o | output | 1 | Duty-cycle reduction request on over-voltage |

## Verification
A wrong supply or line memory appears as a wrong cause_o one edge before state_o follows it. A hysteresis that fails to hold in the dead band shows up as a state that leaves STANDBY or OFF without the set flag. A mis-decoded state appears at once as the gate enabled together with a fault or a clamp. The synchronizer depth is observable as the exact edge at which state_o moves after a flag change, so a missing or extra stage shows as a one-cycle shift.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_STBY  = 2'd3
  } sup_state_e;

  typedef enum logic [1:0] {
    CZ_NONE  = 2'd0,
    CZ_OPEN  = 2'd1,
    CZ_BROWN = 2'd2,
    CZ_LOCK  = 2'd3
  } cause_e;

  // Bit positions of the raw flag bus handed to the synchronizer bank.
  localparam int FL_VON   = 0;
  localparam int FL_VLOW  = 1;
  localparam int FL_LHI   = 2;
  localparam int FL_LLO   = 3;
  localparam int FL_OPEN  = 4;
  localparam int FL_OVP   = 5;
  localparam int FL_REACH = 6;
  localparam int FLAG_W   = 7;

  // Set/clear memory; the clearing flag dominates.
  function automatic logic hyst_next(input logic cur, input logic set, input logic clr);
    if (clr)      return 1'b0;
    else if (set) return 1'b1;
    else          return cur;
  endfunction

  function automatic cause_e cause_of(input logic vcc_ok, input logic line_ok,
                                      input logic loop_ok);
    if (!vcc_ok)       return CZ_LOCK;
    else if (!line_ok) return CZ_BROWN;
    else if (!loop_ok) return CZ_OPEN;
    else               return CZ_NONE;
  endfunction

  function automatic sup_state_e next_state(input sup_state_e cur, input logic vcc_ok,
                                            input logic line_ok, input logic loop_ok,
                                            input logic reach);
    logic all_ok;
    all_ok = vcc_ok && line_ok && loop_ok;
    if (!vcc_ok) return ST_OFF;
    case (cur)
      ST_OFF:   return all_ok ? ST_START : ST_STBY;
      ST_STBY:  return all_ok ? ST_START : ST_STBY;
      ST_START: begin
        if (!all_ok)    return ST_STBY;
        else if (reach) return ST_RUN;
        else            return ST_START;
      end
      default:  return all_ok ? ST_RUN : ST_STBY;
    endcase
  endfunction

endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], raw_i[b]};
    end
    assign sync_o[b] = chain[LAST];
  end
endmodule

// File: rtl/pfc_cond.sv
module pfc_cond
  import pfc_sup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              vcc_ok_o,
  output logic              line_ok_o,
  output logic              loop_ok_o,
  output logic              ovp_o,
  output logic              reach_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_ok_o  <= 1'b0;
      line_ok_o <= 1'b0;
      loop_ok_o <= 1'b0;
      ovp_o     <= 1'b0;
      reach_o   <= 1'b0;
    end else begin
      vcc_ok_o  <= hyst_next(vcc_ok_o, flags_i[FL_VON], flags_i[FL_VLOW]);
      line_ok_o <= hyst_next(line_ok_o, flags_i[FL_LHI], flags_i[FL_LLO]);
      loop_ok_o <= !flags_i[FL_OPEN];
      ovp_o     <= flags_i[FL_OVP];
      reach_o   <= flags_i[FL_REACH];
    end
  end
endmodule

// File: rtl/pfc_sup_fsm.sv
module pfc_sup_fsm
  import pfc_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_ok_i,
  input  logic       line_ok_i,
  input  logic       loop_ok_i,
  input  logic       reach_i,
  output sup_state_e state_o
);
  sup_state_e state_d;

  always_comb state_d = next_state(state_o, vcc_ok_i, line_ok_i, loop_ok_i, reach_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= ST_OFF;
    else        state_o <= state_d;
  end
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_low_i,
  input  logic       line_high_i,
  input  logic       line_low_i,
  input  logic       fb_open_i,
  input  logic       fb_ovp_i,
  input  logic       out_reached_i,
  output logic [1:0] state_o,
  output logic [1:0] cause_o,
  output logic       gate_en_o,
  output logic       fault_o,
  output logic       standby_o,
  output logic       startup_o,
  output logic       ovp_cut_o
);
  logic [FLAG_W-1:0] raw_flags;
  logic [FLAG_W-1:0] sync_flags;
  logic              vcc_ok, line_ok, loop_ok, ovp_q, reach_q;
  sup_state_e        state_q;
  cause_e            cause_w;

  always_comb begin
    raw_flags           = '0;
    raw_flags[FL_VON]   = vcc_on_i;
    raw_flags[FL_VLOW]  = vcc_low_i;
    raw_flags[FL_LHI]   = line_high_i;
    raw_flags[FL_LLO]   = line_low_i;
    raw_flags[FL_OPEN]  = fb_open_i;
    raw_flags[FL_OVP]   = fb_ovp_i;
    raw_flags[FL_REACH] = out_reached_i;
  end

  pfc_flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_flags), .sync_o(sync_flags)
  );

  pfc_cond u_cond (
    .clk(clk), .rst_n(rst_n), .flags_i(sync_flags),
    .vcc_ok_o(vcc_ok), .line_ok_o(line_ok), .loop_ok_o(loop_ok),
    .ovp_o(ovp_q), .reach_o(reach_q)
  );

  pfc_sup_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .vcc_ok_i(vcc_ok), .line_ok_i(line_ok),
    .loop_ok_i(loop_ok), .reach_i(reach_q), .state_o(state_q)
  );

  always_comb cause_w = cause_of(vcc_ok, line_ok, loop_ok);

  assign state_o   = state_q;
  assign cause_o   = cause_w;
  assign gate_en_o = (state_q == ST_START) || (state_q == ST_RUN);
  assign fault_o   = (state_q == ST_OFF) || (state_q == ST_STBY);
  assign standby_o = (state_q == ST_STBY);
  assign startup_o = (state_q == ST_START);
  assign ovp_cut_o = gate_en_o && ovp_q;
endmodule

// File: rtl/pfc_supervisor_chk.sv
module pfc_supervisor_chk
  import pfc_sup_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state_o,
  input logic [1:0] cause_o,
  input logic       gate_en_o,
  input logic       fault_o,
  input logic       standby_o,
  input logic       startup_o,
  input logic       ovp_cut_o
);
  assert_lockout_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cause_o == CZ_LOCK |=> state_o == ST_OFF);

  assert_inhibit_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == CZ_OPEN || cause_o == CZ_BROWN) |=> state_o == ST_STBY);

  assert_start_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_START && $past(state_o) != ST_START) |-> $past(cause_o) == CZ_NONE);

  assert_run_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RUN && $past(state_o) != ST_RUN) |-> $past(state_o) == ST_START);

  assert_standby_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> (fault_o && !gate_en_o && !startup_o));

  assert_ovp_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_cut_o |-> gate_en_o);
endmodule

bind pfc_supervisor pfc_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .cause_o(cause_o),
  .gate_en_o(gate_en_o), .fault_o(fault_o), .standby_o(standby_o),
  .startup_o(startup_o), .ovp_cut_o(ovp_cut_o)
);

// File: tb/pfc_supervisor_tb.sv
module pfc_supervisor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic von = 0, vlow = 0, lhi = 0, llo = 0, opn = 0, ovp = 0, reach = 0;
  logic [1:0] state, cause;
  logic gate, fault, stby, start, cut;
  int compared = 0, mismatched = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] st;
    logic [1:0] cz;
    logic       ov;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  pfc_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .vcc_on_i(von), .vcc_low_i(vlow),
    .line_high_i(lhi), .line_low_i(llo), .fb_open_i(opn), .fb_ovp_i(ovp),
    .out_reached_i(reach), .state_o(state), .cause_o(cause),
    .gate_en_o(gate), .fault_o(fault), .standby_o(stby),
    .startup_o(start), .ovp_cut_o(cut)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Compare all outputs with values derived from the expected state code.
  task automatic compare(input exp_t e);
    chk(e.tag, "state", state, e.st);
    chk(e.tag, "cause", cause, e.cz);
    chk(e.tag, "gate", gate, (e.st == 2'd1 || e.st == 2'd2));
    chk(e.tag, "fault", fault, (e.st == 2'd0 || e.st == 2'd3));
    chk(e.tag, "standby", stby, (e.st == 2'd3));
    chk(e.tag, "startup", start, (e.st == 2'd1));
    chk(e.tag, "ovp_cut", cut, e.ov);
  endtask

  task automatic step(input logic [6:0] f, input logic [1:0] st, input logic [1:0] cz,
                      input logic ov, input string tag);
    exp_t e;
    @(negedge clk);
    {reach, ovp, opn, llo, lhi, vlow, von} = f;
    repeat (6) @(negedge clk);
    e.st = st; e.cz = cz; e.ov = ov; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  // Monitor: pops expected items and compares away from the clock edge.
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      compare(e);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // flag vector order: {reach, ovp, open, line_low, line_high, vcc_low, vcc_on}
  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    e.st = 2'd0; e.cz = 2'd3; e.ov = 1'b0; e.tag = "R1 in reset";
    compare(e);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e.tag = "R1 after reset";
    compare(e);

    step(7'b0000001, 2'd3, 2'd2, 0, "R5 R6 supply good line not yet -> STANDBY");

    // R2 latency: drive line-high, cause moves at edge 3, state at edge 4.
    @(negedge clk);
    lhi = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "cause before edge 3", cause, 2);
    @(negedge clk);
    chk("R2", "cause at edge 3", cause, 0);
    chk("R2", "state at edge 3", state, 3);
    @(negedge clk);
    chk("R2", "state at edge 4", state, 1);

    step(7'b0000101, 2'd1, 2'd0, 0, "R8 R9 STANDBY exits to STARTUP");
    step(7'b0000000, 2'd1, 2'd0, 0, "R3 R6 dead band holds");
    step(7'b1000000, 2'd2, 2'd0, 0, "R9 reached -> NORMAL");
    step(7'b1100000, 2'd2, 2'd0, 1, "R10 ovp in NORMAL cuts duty only");
    step(7'b0010000, 2'd3, 2'd1, 0, "R7 open loop -> STANDBY");
    step(7'b0000000, 2'd1, 2'd0, 0, "R8 loop restored -> STARTUP");
    step(7'b0011000, 2'd3, 2'd2, 0, "R6 R11 brown-out over open loop");
    step(7'b0100000, 2'd3, 2'd2, 0, "R6 R10 band keeps brown-out, ovp ignored");
    step(7'b0000100, 2'd1, 2'd0, 0, "R6 line high restores -> STARTUP");
    step(7'b0001011, 2'd0, 2'd3, 0, "R3 R4 R11 lockout wins");
    step(7'b0000000, 2'd0, 2'd3, 0, "R3 supply band holds lockout");
    step(7'b0000101, 2'd1, 2'd0, 0, "R5 OFF -> STARTUP when all good");
    step(7'b0000010, 2'd0, 2'd3, 0, "R4 lockout from STARTUP");
    step(7'b0010001, 2'd3, 2'd1, 0, "R5 R7 OFF with open loop -> STANDBY");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule